// File: doc/BRIEF.md
# Five-Source Vectored Interrupt Controller

This block collects interrupt requests for a small 8-bit controller and presents one request at a time to the CPU, together with the vector address of its service routine. It serves five sources: two external pins (active low), two timer overflow events and a serial port whose receive and transmit flags share one vector. Each external pin can be sensed on a falling edge, where a flag is latched, or on a low level, where the flag simply follows the pin.

Pending sources pass through a per-source mask and a master enable. A per-source priority bit splits them into a high and a low level. The CPU takes a request by pulsing an acknowledge while the request is visible. On that edge the block records which level is now in service and clears the source's flag when the hardware owns it. A return pulse ends the innermost service. A low-level routine can be interrupted by a high-level request, and a high-level routine cannot be interrupted by anything.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, irq_req_o is 0, irq_vec_o is 0000h, and neither in-service output is set. irq_vec_o reads 0000h whenever no request is presented.
- R2: The source index is 0 for external pin 0, 1 for timer 0, 2 for external pin 1, 3 for timer 1 and 4 for serial. The vector of source k is 0003h + 8·k, so the vectors are 0003h, 000Bh, 0013h, 001Bh and 0023h.
- R3: With ext_edge_i[i]=1, a falling edge on ext_n_i[i] latches the source flag one clock later. The flag stays set after the pin returns high, and it is cleared by the acknowledge that vectors to that source.
- R4: With ext_edge_i[i]=0, the source flag equals the inverted pin as registered on the previous clock. Nothing is latched, and an acknowledge does not clear it.
- R5: A one-cycle pulse on tmr_ovf_i[j] sets the timer flag. An acknowledge that vectors to that timer clears it, and a new pulse in the same cycle wins over the clear.
- R6: The serial source is pending while ser_rx_i or ser_tx_i is 1, and no acknowledge clears it.
- R7: A source can request only when its mask_i bit is 1 and master_en_i is 1.
- R8: A pending source whose prio_i bit is 1 wins over every pending source whose bit is 0.
- R9: Among pending sources of the same priority, the lowest source index wins.
- R10: While svc_lo_o is set, only high-priority sources may request. While svc_hi_o is set, no source may request. An acknowledge sets svc_hi_o or svc_lo_o according to the priority of the source it takes.
- R11: A reti_i pulse clears svc_hi_o if it is set, and otherwise clears svc_lo_o.
- R12: An irq_ack_i pulse while irq_req_o is 0 changes no flag and no in-service state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_n_i | input | 2 | External interrupt pins, active low |
| ext_edge_i | input | 2 | Per pin: 1 = falling-edge latched, 0 = low level |
| tmr_ovf_i | input | 2 | Timer overflow pulses |
| ser_rx_i | input | 1 | Serial receive flag |
| ser_tx_i | input | 1 | Serial transmit flag |
| mask_i | input | 5 | Per-source enable, indexed by source number |
| master_en_i | input | 1 | Master enable gating all sources |
| prio_i | input | 5 | Per-source priority, 1 = high |
| irq_ack_i | input | 1 | CPU takes the presented request |
| reti_i | input | 1 | Return from the current service routine |
| irq_req_o | output | 1 | A request is presented |
| irq_vec_o | output | 16 | Vector address of the presented request |
| svc_hi_o | output | 1 | A high-priority routine is in service |
| svc_lo_o | output | 1 | A low-priority routine is in service |

## Verification
The hardest state to reach is a nested service. This needs a low-priority routine already acknowledged, a high-priority request arriving during it, that request being acknowledged, and then two returns unwinding in the right order. Random acknowledge and return pulses alone rarely build this stack with the intended flags still pending. A directed sequence therefore latches two timer flags, takes the low one, raises the priority of the other, and walks through both returns while the serial flag is held high to show that high service blocks everything. The random phase then drives the pins, the modes, the pulses, the mask, the priorities and the handshake, and compares every cycle against a bench model.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC       = 5;
    localparam int NEXT       = 2;
    localparam int NTMR       = 2;
    localparam int IDX_W      = $clog2(NSRC);
    localparam int VEC_W      = 16;
    localparam logic [VEC_W-1:0] VEC_BASE = 16'h0003;
    localparam int VEC_SHIFT  = 3;   // 8-byte spacing

    typedef enum logic [IDX_W-1:0] {
        SRC_EXT0 = 3'd0,
        SRC_TMR0 = 3'd1,
        SRC_EXT1 = 3'd2,
        SRC_TMR1 = 3'd3,
        SRC_SER  = 3'd4
    } src_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } svc_t;
endpackage

// File: rtl/irq_ext_flag.sv
module irq_ext_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic pin;
        logic latched;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pin = pin_n;
        if (!edge_mode) begin
            st_d.latched = 1'b0;
        end else if (st_q.pin && !pin_n) begin
            st_d.latched = 1'b1;
        end else if (clr) begin
            st_d.latched = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pin: 1'b1, latched: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = edge_mode ? st_q.latched : ~st_q.pin;
endmodule

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    typedef struct packed {
        logic f;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set) begin
            st_d.f = 1'b1;
        end else if (clr) begin
            st_d.f = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.f;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N  = 5,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  prio,
    input  logic          busy_hi,
    input  logic          busy_lo,
    output logic          valid,
    output logic [IW-1:0] win_idx,
    output logic          win_hi
);
    logic [N-1:0]  hi_set;
    logic [N-1:0]  lo_set;
    logic [IW-1:0] hi_idx;
    logic [IW-1:0] lo_idx;

    assign hi_set = pend & prio;
    assign lo_set = pend & ~prio;

    // lowest index wins: scan downwards, last hit overrides
    always_comb begin
        hi_idx = '0;
        lo_idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (hi_set[k]) hi_idx = IW'(k);
            if (lo_set[k]) lo_idx = IW'(k);
        end
    end

    always_comb begin
        valid   = 1'b0;
        win_idx = '0;
        win_hi  = 1'b0;
        if (!busy_hi) begin
            if (|hi_set) begin
                valid   = 1'b1;
                win_idx = hi_idx;
                win_hi  = 1'b1;
            end else if (!busy_lo && (|lo_set)) begin
                valid   = 1'b1;
                win_idx = lo_idx;
            end
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  ext_n_i,
    input  logic [1:0]  ext_edge_i,
    input  logic [1:0]  tmr_ovf_i,
    input  logic        ser_rx_i,
    input  logic        ser_tx_i,
    input  logic [4:0]  mask_i,
    input  logic        master_en_i,
    input  logic [4:0]  prio_i,
    input  logic        irq_ack_i,
    input  logic        reti_i,
    output logic        irq_req_o,
    output logic [15:0] irq_vec_o,
    output logic        svc_hi_o,
    output logic        svc_lo_o
);
    logic [NSRC-1:0]  raw;
    logic [NSRC-1:0]  pend;
    logic [NSRC-1:0]  clr;
    logic             win_valid;
    logic [IDX_W-1:0] win_idx;
    logic             win_hi;
    logic             take;
    svc_t             svc_d, svc_q;

    // external pins sit at even indices 0 and 2
    for (genvar i = 0; i < NEXT; i++) begin : g_ext
        irq_ext_flag u_ext (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_n_i[i]),
            .edge_mode (ext_edge_i[i]),
            .clr       (clr[2*i]),
            .flag      (raw[2*i])
        );
    end

    // timers sit at odd indices 1 and 3
    for (genvar j = 0; j < NTMR; j++) begin : g_tmr
        irq_sticky_flag u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (tmr_ovf_i[j]),
            .clr   (clr[2*j+1]),
            .flag  (raw[2*j+1])
        );
    end

    assign raw[SRC_SER] = ser_rx_i | ser_tx_i;
    assign pend         = raw & mask_i & {NSRC{master_en_i}};

    irq_pick #(.N(NSRC)) u_pick (
        .pend    (pend),
        .prio    (prio_i),
        .busy_hi (svc_q.hi),
        .busy_lo (svc_q.lo),
        .valid   (win_valid),
        .win_idx (win_idx),
        .win_hi  (win_hi)
    );

    assign take = irq_ack_i & win_valid;
    assign clr  = take ? (NSRC'(1) << win_idx) : '0;

    always_comb begin
        svc_d = svc_q;
        if (reti_i) begin
            if (svc_q.hi) svc_d.hi = 1'b0;
            else          svc_d.lo = 1'b0;
        end
        if (take) begin
            if (win_hi) svc_d.hi = 1'b1;
            else        svc_d.lo = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            svc_q <= '0;
        end else begin
            svc_q <= svc_d;
        end
    end

    assign irq_req_o = win_valid;
    assign irq_vec_o = win_valid ? (VEC_BASE + (VEC_W'(win_idx) << VEC_SHIFT)) : '0;
    assign svc_hi_o  = svc_q.hi;
    assign svc_lo_o  = svc_q.lo;
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        master_en_i,
    input logic        irq_ack_i,
    input logic        reti_i,
    input logic        irq_req_o,
    input logic [15:0] irq_vec_o,
    input logic        svc_hi_o,
    input logic        svc_lo_o
);
    assert_idle_vec_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req_o |-> irq_vec_o == 16'h0000);

    assert_vec_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (irq_vec_o[2:0] == 3'b011 && irq_vec_o <= 16'h0023));

    assert_master_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en_i |-> !irq_req_o);

    assert_hi_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        svc_hi_o |-> !irq_req_o);

    assert_reti_pops_hi_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && svc_hi_o) |=> !svc_hi_o);

    assert_stray_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && !irq_req_o && !reti_i) |=> ($stable(svc_hi_o) && $stable(svc_lo_o)));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_en_i (master_en_i),
    .irq_ack_i   (irq_ack_i),
    .reti_i      (reti_i),
    .irq_req_o   (irq_req_o),
    .irq_vec_o   (irq_vec_o),
    .svc_hi_o    (svc_hi_o),
    .svc_lo_o    (svc_lo_o)
);

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ext_n = 2'b11;
    logic [1:0]  ext_edge = 2'b00;
    logic [1:0]  tmr_ovf = 2'b00;
    logic        ser_rx = 1'b0;
    logic        ser_tx = 1'b0;
    logic [4:0]  mask = 5'b00000;
    logic        master = 1'b0;
    logic [4:0]  prio = 5'b00000;
    logic        ack = 1'b0;
    logic        reti = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic        svc_hi;
    logic        svc_lo;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model state
    logic [1:0] m_pin = 2'b11;
    logic [1:0] m_lat = 2'b00;
    logic [1:0] m_tf  = 2'b00;
    bit         m_hi  = 0;
    bit         m_lo  = 0;

    always #4 clk = ~clk;

    irq_vector_ctrl u0 (
        .clk (clk), .rst_n (rst_n), .ext_n_i (ext_n), .ext_edge_i (ext_edge),
        .tmr_ovf_i (tmr_ovf), .ser_rx_i (ser_rx), .ser_tx_i (ser_tx),
        .mask_i (mask), .master_en_i (master), .prio_i (prio),
        .irq_ack_i (ack), .reti_i (reti), .irq_req_o (irq_req),
        .irq_vec_o (irq_vec), .svc_hi_o (svc_hi), .svc_lo_o (svc_lo)
    );

    function automatic logic [4:0] m_pend();
        logic e0, e1;
        e0 = ext_edge[0] ? m_lat[0] : ~m_pin[0];
        e1 = ext_edge[1] ? m_lat[1] : ~m_pin[1];
        return {ser_rx | ser_tx, m_tf[1], e1, m_tf[0], e0} & mask & {5{master}};
    endfunction

    function automatic int m_pick();
        logic [4:0] p;
        p = m_pend();
        if (m_hi) return -1;
        for (int k = 0; k < 5; k++) if (p[k] && prio[k]) return k;
        if (m_lo) return -1;
        for (int k = 0; k < 5; k++) if (p[k] && !prio[k]) return k;
        return -1;
    endfunction

    function automatic logic [15:0] m_vec();
        int w;
        w = m_pick();
        return (w < 0) ? 16'h0000 : 16'(16'h0003 + 8 * w);
    endfunction

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // advance the model with the inputs held now, clock, compare at negedge
    task automatic tick();
        int  w;
        bit  tk;
        w  = m_pick();
        tk = ack && (w >= 0);
        for (int i = 0; i < 2; i++) begin
            if (!ext_edge[i])                m_lat[i] = 1'b0;
            else if (m_pin[i] && !ext_n[i])  m_lat[i] = 1'b1;
            else if (tk && w == 2 * i)       m_lat[i] = 1'b0;
            m_pin[i] = ext_n[i];
            if (tmr_ovf[i])                  m_tf[i] = 1'b1;
            else if (tk && w == 2 * i + 1)   m_tf[i] = 1'b0;
        end
        if (reti) begin
            if (m_hi) m_hi = 0; else m_lo = 0;
        end
        if (tk) begin
            if (prio[w]) m_hi = 1; else m_lo = 1;
        end
        @(posedge clk);
        @(negedge clk);
        tmr_ovf = 2'b00;
        ack     = 1'b0;
        reti    = 1'b0;
        chk("R2 model vector", irq_vec, m_vec());
        chk("R10 model svc", {14'd0, svc_hi, svc_lo}, {14'd0, m_hi, m_lo});
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        chk("R1 reset req", {15'd0, irq_req}, 16'd0);
        chk("R1 reset vec", irq_vec, 16'h0000);
        chk("R1 reset svc", {14'd0, svc_hi, svc_lo}, 16'd0);
        rst_n = 1'b1;
        tick();

        master = 1; mask = 5'b11111; prio = 5'b00000;

        // R3 edge latch on ext0
        ext_edge = 2'b11;
        tick();
        ext_n[0] = 1'b0; tick();
        chk("R3 edge latched", irq_vec, 16'h0003);
        ext_n[0] = 1'b1; tick();
        chk("R3 stays after pin high", irq_vec, 16'h0003);
        ack = 1; tick();
        chk("R10 low service", {14'd0, svc_hi, svc_lo}, 16'd1);
        reti = 1; tick();
        chk("R3 cleared on vectoring", {15'd0, irq_req}, 16'd0);

        // R4 level mode ext1
        ext_edge = 2'b00;
        ext_n[1] = 1'b0; tick();
        chk("R4 level follows pin", irq_vec, 16'h0013);
        ack = 1; tick(); reti = 1; tick();
        chk("R4 not cleared by ack", irq_vec, 16'h0013);
        ext_n[1] = 1'b1; tick();
        chk("R4 not latched", {15'd0, irq_req}, 16'd0);

        // R5 timer 1
        tmr_ovf = 2'b10; tick();
        chk("R5 timer1 vector", irq_vec, 16'h001B);
        ack = 1; tick(); reti = 1; tick();
        chk("R5 timer cleared", {15'd0, irq_req}, 16'd0);

        // R6 serial
        ser_tx = 1; tick();
        chk("R6 serial vector", irq_vec, 16'h0023);
        ack = 1; tick(); reti = 1; tick();
        chk("R6 not cleared", irq_vec, 16'h0023);
        ser_tx = 0; ser_rx = 1; tick();
        chk("R6 receive also", irq_vec, 16'h0023);
        ser_rx = 0; tick();

        // R8, R9, R10, R11 nesting
        tmr_ovf = 2'b11; tick();
        chk("R9 fixed order", irq_vec, 16'h000B);
        prio = 5'b01000; tick();
        chk("R8 high wins", irq_vec, 16'h001B);
        prio = 5'b00000; ack = 1; tick();
        chk("R10 low blocks low", {15'd0, irq_req}, 16'd0);
        prio = 5'b01000; tick();
        chk("R10 high preempts", irq_vec, 16'h001B);
        ack = 1; ser_tx = 1; tick();
        chk("R10 both in service", {14'd0, svc_hi, svc_lo}, 16'd3);
        chk("R10 high blocks all", {15'd0, irq_req}, 16'd0);
        reti = 1; tick();
        chk("R11 pops high first", {14'd0, svc_hi, svc_lo}, 16'd1);
        reti = 1; tick();
        chk("R11 pops low", {14'd0, svc_hi, svc_lo}, 16'd0);

        // R7 masking
        mask = 5'b01111; tick();
        chk("R7 source mask", {15'd0, irq_req}, 16'd0);
        mask = 5'b11111; master = 0; tick();
        chk("R7 master off", {15'd0, irq_req}, 16'd0);

        // R12 stray ack
        ack = 1; tick();
        chk("R12 stray ack", {14'd0, svc_hi, svc_lo}, 16'd0);
        master = 1; ser_tx = 0; prio = 5'b00000; tick();

        // random phase
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(3) == 0) ext_n[0] = ~ext_n[0];
            if ($urandom_range(3) == 0) ext_n[1] = ~ext_n[1];
            if ($urandom_range(40) == 0) ext_edge = 2'($urandom_range(3));
            tmr_ovf = ($urandom_range(5) == 0) ? 2'($urandom_range(3)) : 2'b00;
            ser_rx  = ($urandom_range(9) == 0);
            ser_tx  = ($urandom_range(9) == 0);
            if ($urandom_range(30) == 0) mask = 5'($urandom_range(31)) | 5'b10101;
            master  = ($urandom_range(15) != 0);
            if ($urandom_range(20) == 0) prio = 5'($urandom_range(31));
            ack     = ($urandom_range(2) == 0);
            reti    = ($urandom_range(4) == 0);
            tick();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule